// File: doc/BRIEF.md
# Privileged Virtual Segment Decoder

This block takes a 32-bit virtual address together with the current privilege mode and decides, one cycle later, how that address may be used. Depending on the top bits of the address and on the mode, the access is either turned straight into a physical address, handed on to a downstream translation lookaside buffer (TLB), or rejected with a bad-address code.

A mode select input picks between two schemes. In table mode the mapped segments go to the TLB. In fixed mode no TLB exists: the low user half is moved up by 1 GiB and the upper mapped segments pass through unchanged. An error-level status bit overrides the user half in both schemes. When it is set, the user half passes through untranslated.

Each request is qualified by a valid strobe. The outcome appears on registered outputs one clock later and stays there until the next request.

Top module: `vseg_decoder`

## Requirements
- R1: After reset, out_valid, tlb_req, can_read and can_write are 0, phys_addr is 0 and result is 0.
- R2: out_valid is high exactly in the cycle after a cycle with req_valid high. When req_valid is low, phys_addr, result, tlb_req and the permissions keep their previous values.
- R3: In table mode (fixed_map=0) with err_level=0, an address below 0x80000000 raises tlb_req with result 0 (match), phys_addr 0 and both permissions 0, in every privilege mode.
- R4: With err_level=1, an address below 0x80000000 gives phys_addr equal to the address, read and write allowed, result 0 and no tlb_req, in both schemes and every privilege mode.
- R5: An address from 0x80000000 to 0x9FFFFFFF in kernel mode (priv=0) gives phys_addr = address - 0x80000000 with read and write allowed and result 0.
- R6: An address from 0xA0000000 to 0xBFFFFFFF in kernel mode gives phys_addr = address - 0xA0000000 with read and write allowed and result 0.
- R7: An address from 0xC0000000 to 0xDFFFFFFF is allowed in kernel or supervisor mode (priv=0 or 1). In table mode it raises tlb_req with result 0.
- R8: An address from 0xE0000000 upward is allowed only in kernel mode. In table mode it raises tlb_req with result 0.
- R9: An access to a segment the mode may not use gives result 1 (bad address) with tlb_req, both permissions and phys_addr all 0. priv=2 is user mode, and the reserved code priv=3 is treated as user mode.
- R10: In fixed mode with err_level=0, an address below 0x80000000 gives phys_addr = address + 0x40000000 with read and write allowed, result 0 and no tlb_req.
- R11: In fixed mode, an allowed address at 0xC0000000 or above gives phys_addr equal to the address with read and write allowed and result 0. tlb_req is never raised in fixed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe qualifying the inputs below |
| vaddr | input | 32 | Virtual address |
| priv | input | 2 | Privilege mode: 0 kernel, 1 supervisor, 2 user, 3 treated as user |
| err_level | input | 1 | Error-level status bit |
| fixed_map | input | 1 | 1 selects the fixed-mapping scheme, 0 the table scheme |
| out_valid | output | 1 | High for one cycle per request, one cycle after it |
| phys_addr | output | 32 | Physical address for untranslated outcomes, else 0 |
| can_read | output | 1 | Read permitted (untranslated outcomes) |
| can_write | output | 1 | Write permitted (untranslated outcomes) |
| tlb_req | output | 1 | Address must be translated by the downstream TLB |
| result | output | 3 | Outcome code: 0 match, 1 bad address (2 to 4 reserved for the TLB) |

## Verification
The hardest situations to reach are those where several controls meet: error-level set in fixed mode, the reserved privilege code, and the supervisor-mapped segment seen from each mode. Each of these selects a different branch for the same address. The stimulus therefore sweeps every privilege code against every combination of error-level and scheme, for addresses in all eight top-bit octants, including the first and last word of each octant. Between requests, idle cycles with changed inputs confirm that nothing moves without a strobe.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'd0,
        PRIV_SUPER  = 2'd1,
        PRIV_USER   = 2'd2,
        PRIV_RSVD   = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        SEG_USER   = 3'd0,
        SEG_KDIR0  = 3'd1,
        SEG_KDIR1  = 3'd2,
        SEG_SUPMAP = 3'd3,
        SEG_KMAP   = 3'd4
    } seg_e;

    typedef enum logic [2:0] {
        RES_MATCH   = 3'd0,
        RES_BADADDR = 3'd1,
        RES_NOMATCH = 3'd2,
        RES_INVALID = 3'd3,
        RES_DIRTY   = 3'd4
    } res_e;

endpackage

// File: rtl/vseg_region.sv
module vseg_region
    import vseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    output seg_e              seg
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        case (vaddr[TOP -: 3])
            3'b100:  seg = SEG_KDIR0;
            3'b101:  seg = SEG_KDIR1;
            3'b110:  seg = SEG_SUPMAP;
            3'b111:  seg = SEG_KMAP;
            default: seg = SEG_USER;
        endcase
    end
endmodule

// File: rtl/vseg_priv.sv
module vseg_priv
    import vseg_pkg::*;
(
    input  seg_e       seg,
    input  logic [1:0] priv,
    output logic       allowed
);
    logic is_kernel;
    logic is_super;

    always_comb begin
        is_kernel = (priv == PRIV_KERNEL);
        is_super  = (priv == PRIV_SUPER);
        case (seg)
            SEG_USER:   allowed = 1'b1;
            SEG_SUPMAP: allowed = is_kernel | is_super;
            default:    allowed = is_kernel;
        endcase
    end
endmodule

// File: rtl/vseg_map.sv
module vseg_map
    import vseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  seg_e              seg,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              err_level,
    input  logic              fixed_map,
    output logic [ADDR_W-1:0] paddr,
    output logic              direct,
    output logic              to_tlb
);
    localparam int                LOW_W     = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] FIXED_OFS = {2'b01, {(ADDR_W-2){1'b0}}};

    always_comb begin
        paddr  = '0;
        direct = 1'b0;
        to_tlb = 1'b0;
        case (seg)
            SEG_USER: begin
                if (err_level) begin
                    paddr  = vaddr;
                    direct = 1'b1;
                end else if (fixed_map) begin
                    paddr  = vaddr + FIXED_OFS;
                    direct = 1'b1;
                end else begin
                    to_tlb = 1'b1;
                end
            end
            SEG_KDIR0, SEG_KDIR1: begin
                paddr  = {3'b000, vaddr[LOW_W-1:0]};
                direct = 1'b1;
            end
            default: begin
                if (fixed_map) begin
                    paddr  = vaddr;
                    direct = 1'b1;
                end else begin
                    to_tlb = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        AST_ONE_ROUTE: assert (direct ^ to_tlb); // R3
    end
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
    import vseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        priv,
    input  logic              err_level,
    input  logic              fixed_map,
    output logic              out_valid,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              can_read,
    output logic              can_write,
    output logic              tlb_req,
    output logic [2:0]        result
);
    localparam int TOP = ADDR_W - 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pa;
        logic              rd;
        logic              wr;
        logic              tlb;
        res_e              res;
    } state_s;

    seg_e              seg;
    logic              allowed;
    logic [ADDR_W-1:0] map_pa;
    logic              map_direct;
    logic              map_tlb;
    state_s            st_d;
    state_s            st_q;

    vseg_region #(.ADDR_W(ADDR_W)) region_i (
        .vaddr (vaddr),
        .seg   (seg)
    );

    vseg_priv priv_i (
        .seg     (seg),
        .priv    (priv),
        .allowed (allowed)
    );

    vseg_map #(.ADDR_W(ADDR_W)) map_i (
        .seg       (seg),
        .vaddr     (vaddr),
        .err_level (err_level),
        .fixed_map (fixed_map),
        .paddr     (map_pa),
        .direct    (map_direct),
        .to_tlb    (map_tlb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.pa  = '0;
            st_d.rd  = 1'b0;
            st_d.wr  = 1'b0;
            st_d.tlb = 1'b0;
            st_d.res = RES_MATCH;
            if (!allowed) begin
                st_d.res = RES_BADADDR;
            end else if (map_tlb) begin
                st_d.tlb = 1'b1;
            end else if (map_direct) begin
                st_d.pa = map_pa;
                st_d.rd = 1'b1;
                st_d.wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, pa: '0, rd: 1'b0, wr: 1'b0, tlb: 1'b0, res: RES_MATCH};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign phys_addr = st_q.pa;
    assign can_read  = st_q.rd;
    assign can_write = st_q.wr;
    assign tlb_req   = st_q.tlb;
    assign result    = st_q.res;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(phys_addr) && $stable(result) && $stable(tlb_req)); // R2
    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result == RES_BADADDR) |-> (!tlb_req && !can_read && !can_write && phys_addr == '0)); // R9
    AST_KSEG_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv != PRIV_KERNEL && vaddr[TOP] && vaddr[TOP-1:TOP-2] != 2'b10)
        |=> result == RES_BADADDR); // R9
    AST_ERL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && err_level && !vaddr[TOP])
        |=> (phys_addr == $past(vaddr) && can_read && can_write && !tlb_req)); // R4
    AST_FIXED_NO_TLB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fixed_map) |=> !tlb_req); // R11
    AST_TLB_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req |-> (!can_read && !can_write && result == RES_MATCH)); // R3
endmodule

// File: tb/vseg_decoder_tb.sv
module vseg_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  priv = '0;
    logic        err_level = 1'b0;
    logic        fixed_map = 1'b0;
    logic        out_valid;
    logic [31:0] phys_addr;
    logic        can_read;
    logic        can_write;
    logic        tlb_req;
    logic [2:0]  result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vseg_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .vaddr     (vaddr),
        .priv      (priv),
        .err_level (err_level),
        .fixed_map (fixed_map),
        .out_valid (out_valid),
        .phys_addr (phys_addr),
        .can_read  (can_read),
        .can_write (can_write),
        .tlb_req   (tlb_req),
        .result    (result)
    );

    // Packed expectation: {vld, pa[31:0], rd, wr, tlb, res[2:0]}
    function automatic logic [38:0] model(input logic [31:0] va, input logic [1:0] pm,
                                          input logic erl, input logic fix);
        logic [31:0] pa;
        logic ok, rw, tlb;
        logic kern, sup;
        kern = (pm == 2'd0);
        sup  = (pm == 2'd1);
        pa = 32'h0; rw = 1'b0; tlb = 1'b0; ok = 1'b1;
        if (!va[31]) begin
            if (erl)      begin pa = va; rw = 1'b1; end
            else if (fix) begin pa = va + 32'h4000_0000; rw = 1'b1; end
            else          tlb = 1'b1;
        end else if (va[31:29] == 3'b100) begin
            ok = kern; pa = va - 32'h8000_0000; rw = 1'b1;
        end else if (va[31:29] == 3'b101) begin
            ok = kern; pa = va - 32'hA000_0000; rw = 1'b1;
        end else begin
            ok = (va[31:29] == 3'b110) ? (kern | sup) : kern;
            if (fix) begin pa = va; rw = 1'b1; end
            else tlb = 1'b1;
        end
        if (!ok) return {1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 3'd1};
        return {1'b1, pa, rw, rw, tlb, 3'd0};
    endfunction

    function automatic string req_tag(input logic [31:0] va, input logic [1:0] pm,
                                      input logic erl, input logic fix);
        logic ok;
        ok = !va[31] || pm == 2'd0 || (va[31:29] == 3'b110 && pm == 2'd1);
        if (!ok) return "R9";
        if (!va[31]) return erl ? "R4" : (fix ? "R10" : "R3");
        case (va[31:29])
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110:  return fix ? "R11" : "R7";
            default: return fix ? "R11" : "R8";
        endcase
    endfunction

    function automatic logic [38:0] observed();
        return {out_valid, phys_addr, can_read, can_write, tlb_req, result};
    endfunction

    task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [28:0] offs [4];
        logic [38:0] last;
        offs[0] = 29'h0000_0000;
        offs[1] = 29'h1FFF_FFFF;
        offs[2] = 29'h0ABC_DEF1;
        offs[3] = 29'h1234_5678;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", observed(), 39'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", observed(), 39'h0);

        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int r = 0; r < 8; r++) begin
                        for (int o = 0; o < 4; o++) begin
                            logic [31:0] va;
                            va = {r[2:0], offs[o]};
                            vaddr     = va;
                            priv      = m[1:0];
                            err_level = e[0];
                            fixed_map = f[0];
                            req_valid = 1'b1;
                            @(negedge clk);
                            last = model(va, m[1:0], e[0], f[0]);
                            check(req_tag(va, m[1:0], e[0], f[0]), observed(), last);
                            if (o == 3) begin
                                // R2: idle cycle with changed inputs
                                req_valid = 1'b0;
                                vaddr     = ~va;
                                priv      = ~m[1:0];
                                err_level = ~e[0];
                                fixed_map = ~f[0];
                                @(negedge clk);
                                check("R2", observed(), {1'b0, last[37:0]});
                            end
                        end
                    end
                end
            end
        end

        // R2: back-to-back strobes keep out_valid high
        req_valid = 1'b1; vaddr = 32'h8000_0010; priv = 2'd0; err_level = 1'b0; fixed_map = 1'b0;
        @(negedge clk);
        check("R5", observed(), model(32'h8000_0010, 2'd0, 1'b0, 1'b0));
        vaddr = 32'hBFFF_FFFC;
        @(negedge clk);
        check("R6", observed(), model(32'hBFFF_FFFC, 2'd0, 1'b0, 1'b0));
        req_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule